// File: doc/BRIEF.md
# Fault Input Conditioner

This block cleans up one raw fault signal before the fault action logic sees it. Three stages act on the signal, and each can be switched on alone or together with the others. A digital pulse-width filter drops short glitches. A blanking timer ignores the fault for a programmed time after a chosen edge of the channel waveform. A qualification gate masks the fault whenever the waveform sits at its inactive level.

The raw fault is treated as a signal that is already synchronous to `clk`. The filter requires the input to hold a new level for a programmed number of consecutive clock samples before it accepts the change. This applies to both the assertion and the release of the fault. The blanking timer reloads on each selected waveform edge. It counts down either on every clock or once every `PRESC_DIV` clocks. The gated result is driven out combinationally from the filter state, the blanking state and the waveform level.

Top module: `fault_cond`

## Requirements
- R1: While `rst_n` is low and `filt_len` is non-zero, `fault_out` is 0 whatever the level of `fault_raw`.
- R2: With `filt_len` = 0, blanking idle and qualification not masking, `fault_out` equals `fault_raw` in the same cycle, with no register in the path.
- R3: With `filt_len` = N > 0, a `fault_raw` pulse that is seen at fewer than N consecutive rising clock edges leaves `fault_out` unchanged.
- R4: With `filt_len` = N > 0, a new `fault_raw` level held for N consecutive rising edges reaches `fault_out` right after the N-th of those edges. This holds for both assertion and release.
- R5: `blank_sel` picks the edge of `wave_out` that starts blanking: 0 = none, 1 = rising (0 to 1), 2 = falling (1 to 0), 3 = both.
- R6: With `blank_slow` = 0 and `blank_len` = L > 0, `fault_out` is forced to 0 from the moment a selected edge appears on `wave_out`. It stays forced through the L rising clock edges that follow the edge where the new level is first sampled, and is free again after the (L+1)-th such edge.
- R7: With `blank_slow` = 1, the blanking count steps once every 64 clocks, so the window ends after 64*L+1 rising edges instead of L+1.
- R8: A selected edge that arrives while a blanking window is running restarts the window at the full `blank_len`.
- R9: With `qual_en` = 1, `fault_out` is 0 for as long as `wave_out` is 0, which is the inactive level.
- R10: With all stages on, `fault_out` is the filtered fault ANDed with not-blanked and not-qualification-masked.
- R11: With `blank_len` = 0, waveform edges never blank the fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fault_raw | input | 1 | Unconditioned fault, synchronous to clk |
| wave_out | input | 1 | Channel waveform level; 0 is inactive |
| filt_len | input | FILT_W | Filter length in clock samples; 0 bypasses the filter |
| blank_sel | input | 2 | Blanking edge select (0 none, 1 rise, 2 fall, 3 both) |
| blank_len | input | BLANK_W | Blanking length in timer ticks; 0 disables blanking |
| blank_slow | input | 1 | 1: blanking timer ticks every PRESC_DIV clocks |
| qual_en | input | 1 | 1: mask the fault while wave_out is inactive |
| fault_out | output | 1 | Conditioned fault |

## Verification
The bench measures the filter at its exact boundary. A pulse one sample short must vanish, and a pulse held exactly N samples must appear after the N-th edge. A filter that is off by one in either direction fails one of these two checks. Blanking windows are timed to the cycle in fast and prescaled modes. A timer that ignored a mid-window edge would reopen the fault too early during the retrigger check. Wrong edge decoding would blank on the unselected edge, or fail to blank on the selected one. Qualification and the combined case check that a filtered fault still stays low while the output is inactive or blanked.

// File: rtl/fault_cond_pkg.sv
package fault_cond_pkg;

   typedef enum logic [1:0] {
      BLK_OFF  = 2'd0,
      BLK_RISE = 2'd1,
      BLK_FALL = 2'd2,
      BLK_BOTH = 2'd3
   } blank_mode_e;

endpackage

// File: rtl/fc_glitch_filter.sv
module fc_glitch_filter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] len,
   output logic             dout
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("fc_glitch_filter: CNT_W must be at least 1");
      end
   endgenerate

   logic             held;
   logic [CNT_W-1:0] run;
   logic [CNT_W:0]   run_nx;

   assign run_nx = {1'b0, run} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         run  <= '0;
      end else if (len == '0) begin
         held <= din;
         run  <= '0;
      end else if (din != held) begin
         if (run_nx == {1'b0, len}) begin
            held <= din;
            run  <= '0;
         end else begin
            run <= run_nx[CNT_W-1:0];
         end
      end else begin
         run <= '0;
      end
   end

   assign dout = (len == '0) ? din : held;

   // R4
   filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held != $past(held)) |-> (held == $past(din)));

   // R3
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len > 1 && din != held && run == '0) |=> (held == $past(held)));

endmodule

// File: rtl/fc_blank_timer.sv
module fc_blank_timer
   import fault_cond_pkg::*;
#(
   parameter int BW        = 8,
   parameter int PRESC_DIV = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wave,
   input  logic [1:0]    mode,
   input  logic [BW-1:0] len,
   input  logic          slow,
   output logic          blank
);

   generate
      if (BW < 1) begin : g_bad_bw
         $error("fc_blank_timer: BW must be at least 1");
      end
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("fc_blank_timer: PRESC_DIV must be at least 1");
      end
   endgenerate

   logic          wave_q;
   logic          rise, fall, edge_hit, tick;
   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave_q <= 1'b0;
      else        wave_q <= wave;
   end

   assign rise = wave & ~wave_q;
   assign fall = ~wave & wave_q;

   always_comb begin
      unique case (blank_mode_e'(mode))
         BLK_RISE: edge_hit = rise;
         BLK_FALL: edge_hit = fall;
         BLK_BOTH: edge_hit = rise | fall;
         default:  edge_hit = 1'b0;
      endcase
   end

   generate
      if (PRESC_DIV > 1) begin : g_presc
         localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
         localparam logic [PW-1:0] PSC_LAST = PW'(PRESC_DIV - 1);
         logic [PW-1:0] psc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             psc <= '0;
            else if (edge_hit)      psc <= '0;
            else if (psc == PSC_LAST) psc <= '0;
            else                    psc <= psc + 1'b1;
         end
         assign tick = slow ? (psc == PSC_LAST) : 1'b1;
      end else begin : g_no_presc
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (edge_hit && len != '0)   cnt <= len;
      else if (cnt != '0 && tick)       cnt <= cnt - 1'b1;
   end

   assign blank = (edge_hit && len != '0) || (cnt != '0);

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && len != '0) |=> (cnt == $past(len)));

   // R6
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !edge_hit) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

   // R11
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len == '0 && cnt == '0) |-> !blank);

endmodule

// File: rtl/fc_mask_combine.sv
module fc_mask_combine #(
   parameter logic INACTIVE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt,
   input  logic blank,
   input  logic wave,
   input  logic qual_en,
   output logic fault
);

   logic qmask;

   assign qmask = qual_en && (wave == INACTIVE_LVL);
   assign fault = filt & ~blank & ~qmask;

   // R9
   qual_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_en && wave == INACTIVE_LVL) |-> !fault);

   // R10
   blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> !fault);

endmodule

// File: rtl/fault_cond.sv
module fault_cond #(
   parameter int   FILT_W       = 4,
   parameter int   BLANK_W      = 8,
   parameter int   PRESC_DIV    = 64,
   parameter logic INACTIVE_LVL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fault_raw,
   input  logic               wave_out,
   input  logic [FILT_W-1:0]  filt_len,
   input  logic [1:0]         blank_sel,
   input  logic [BLANK_W-1:0] blank_len,
   input  logic               blank_slow,
   input  logic               qual_en,
   output logic               fault_out
);

   logic filt_i;
   logic blank_i;

   fc_glitch_filter #(.CNT_W(FILT_W)) filt_u (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fault_raw),
      .len  (filt_len),
      .dout (filt_i)
   );

   fc_blank_timer #(.BW(BLANK_W), .PRESC_DIV(PRESC_DIV)) blank_u (
      .clk  (clk),
      .rst_n(rst_n),
      .wave (wave_out),
      .mode (blank_sel),
      .len  (blank_len),
      .slow (blank_slow),
      .blank(blank_i)
   );

   fc_mask_combine #(.INACTIVE_LVL(INACTIVE_LVL)) comb_u (
      .clk    (clk),
      .rst_n  (rst_n),
      .filt   (filt_i),
      .blank  (blank_i),
      .wave   (wave_out),
      .qual_en(qual_en),
      .fault  (fault_out)
   );

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_len == '0 && !blank_i && !(qual_en && wave_out == INACTIVE_LVL))
      |-> (fault_out == fault_raw));

endmodule

// File: tb/fault_cond_tb_top.sv
module fault_cond_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fault_raw = 1'b0;
   logic       wave_out = 1'b0;
   logic [3:0] filt_len = 4'd0;
   logic [1:0] blank_sel = 2'd0;
   logic [7:0] blank_len = 8'd0;
   logic       blank_slow = 1'b0;
   logic       qual_en = 1'b0;
   logic       fault_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fault_cond dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_raw (fault_raw),
      .wave_out  (wave_out),
      .filt_len  (filt_len),
      .blank_sel (blank_sel),
      .blank_len (blank_len),
      .blank_slow(blank_slow),
      .qual_en   (qual_en),
      .fault_out (fault_out)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic exp, input string req);
      checks++;
      if (fault_out !== exp) begin
         errors++;
         $display("FAIL %s: fault_out=%b expected=%b at %0t", req, fault_out, exp, $time);
      end
   endtask

   task automatic cfg(input int fl, input int sel, input int bl, input logic sl, input logic q);
      fault_raw  = 1'b0;
      filt_len   = 4'(fl);
      blank_sel  = 2'(sel);
      blank_len  = 8'(bl);
      blank_slow = sl;
      qual_en    = q;
      step(20);
   endtask

   task automatic t_reset();
      filt_len  = 4'd3;
      fault_raw = 1'b1;
      step(3);
      chk(1'b0, "R1 reset");
      fault_raw = 1'b0;
      rst_n = 1'b1;
      step(2);
      chk(1'b0, "R1 after release");
   endtask

   task automatic t_bypass();
      cfg(0, 0, 0, 1'b0, 1'b0);
      fault_raw = 1'b1; #1;
      chk(1'b1, "R2 bypass rise");
      fault_raw = 1'b0; #1;
      chk(1'b0, "R2 bypass fall");
   endtask

   task automatic t_filter_short();
      cfg(3, 0, 0, 1'b0, 1'b0);
      fault_raw = 1'b1;
      step(2);
      fault_raw = 1'b0;
      for (int i = 0; i < 5; i++) begin
         step(1);
         chk(1'b0, "R3 short pulse dropped");
      end
   endtask

   task automatic t_filter_pass();
      cfg(3, 0, 0, 1'b0, 1'b0);
      fault_raw = 1'b1;
      step(2);
      chk(1'b0, "R4 not yet asserted");
      step(1);
      chk(1'b1, "R4 asserted after N");
      fault_raw = 1'b0;
      step(2);
      chk(1'b1, "R4 not yet released");
      step(1);
      chk(1'b0, "R4 released after N");
   endtask

   task automatic t_blank_rise();
      wave_out = 1'b0;
      cfg(0, 1, 3, 1'b0, 1'b0);
      fault_raw = 1'b1; #1;
      chk(1'b1, "R6 before edge");
      wave_out = 1'b1; #1;
      chk(1'b0, "R6 edge cycle blanked");
      step(3);
      chk(1'b0, "R6 last blanked cycle");
      step(1);
      chk(1'b1, "R6 window over");
      wave_out = 1'b0; #1;
      chk(1'b1, "R5 falling edge ignored in rise mode");
      step(1);
      chk(1'b1, "R5 falling edge ignored next cycle");
   endtask

   task automatic t_blank_fall();
      wave_out = 1'b0;
      cfg(0, 2, 2, 1'b0, 1'b0);
      fault_raw = 1'b1;
      wave_out = 1'b1; #1;
      chk(1'b1, "R5 rising edge ignored in fall mode");
      step(1);
      wave_out = 1'b0; #1;
      chk(1'b0, "R5 falling edge blanks");
      step(2);
      chk(1'b0, "R5 fall window held");
      step(1);
      chk(1'b1, "R5 fall window over");
   endtask

   task automatic t_blank_off();
      wave_out = 1'b0;
      cfg(0, 0, 5, 1'b0, 1'b0);
      fault_raw = 1'b1;
      wave_out = 1'b1; #1;
      chk(1'b1, "R5 mode 0 rising");
      step(1);
      wave_out = 1'b0; #1;
      chk(1'b1, "R5 mode 0 falling");
   endtask

   task automatic t_blank_retrig();
      wave_out = 1'b0;
      cfg(0, 3, 4, 1'b0, 1'b0);
      fault_raw = 1'b1;
      wave_out = 1'b1;
      step(2);
      wave_out = 1'b0; #1;
      chk(1'b0, "R8 second edge blanked");
      step(4);
      chk(1'b0, "R8 window restarted");
      step(1);
      chk(1'b1, "R8 restarted window over");
   endtask

   task automatic t_blank_slow();
      wave_out = 1'b0;
      cfg(0, 1, 2, 1'b1, 1'b0);
      fault_raw = 1'b1;
      wave_out = 1'b1;
      step(64);
      chk(1'b0, "R7 mid window");
      step(64);
      chk(1'b0, "R7 last prescaled cycle");
      step(1);
      chk(1'b1, "R7 prescaled window over");
   endtask

   task automatic t_blank_zero();
      wave_out = 1'b0;
      cfg(0, 3, 0, 1'b0, 1'b0);
      fault_raw = 1'b1;
      wave_out = 1'b1; #1;
      chk(1'b1, "R11 zero length rise");
      step(1);
      wave_out = 1'b0; #1;
      chk(1'b1, "R11 zero length fall");
   endtask

   task automatic t_qual();
      wave_out = 1'b0;
      cfg(0, 0, 0, 1'b0, 1'b1);
      fault_raw = 1'b1; #1;
      chk(1'b0, "R9 masked while inactive");
      wave_out = 1'b1; #1;
      chk(1'b1, "R9 passes while active");
      wave_out = 1'b0; #1;
      chk(1'b0, "R9 masked again");
      qual_en = 1'b0; #1;
      chk(1'b1, "R9 qual off passes");
   endtask

   task automatic t_combined();
      wave_out = 1'b0;
      cfg(2, 1, 2, 1'b0, 1'b1);
      fault_raw = 1'b1;
      step(2);
      chk(1'b0, "R10 filtered but qual masked");
      wave_out = 1'b1; #1;
      chk(1'b0, "R10 blanked on rise");
      step(2);
      chk(1'b0, "R10 blank held");
      step(1);
      chk(1'b1, "R10 all stages pass");
      fault_raw = 1'b0;
      step(1);
      chk(1'b1, "R10 filter delays release");
      step(1);
      chk(1'b0, "R10 released");
   endtask

   initial begin
      step(1);
      t_reset();
      t_bypass();
      t_filter_short();
      t_filter_pass();
      t_blank_rise();
      t_blank_fall();
      t_blank_off();
      t_blank_retrig();
      t_blank_slow();
      t_blank_zero();
      t_qual();
      t_combined();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule